// File: doc/BRIEF.md
# Register-Mapped Display Identification Reader

This block answers host register accesses as if it were a display I2C controller, handing out the 128-byte identification record of an attached monitor. It does not drive bus pins. Host software chooses a port, programs a command word, polls a status word and pulls the record through a data register, up to four bytes per read. The block follows the controller's bus phase (idle, data, wait) and keeps the status flags that a driver polls.

The record is held in a 128-byte memory that is loaded through a separate preload port. Two per-port flag vectors state whether a monitor is present and whether that port carries DisplayPort, which this controller does not serve. There are four registers, selected by a 2-bit address: 0 is port select, 1 is command, 2 is status and 3 is data. A read and a write may be issued in the same cycle, each with its own address. Read data is combinational while the read strobe is high. All side effects take place at the following clock edge.

Top module: `edid_bus_reader`

## Requirements
- R1: After reset the status register reads 0x0000_0800 (ready, bit 11), the bus phase output is idle (0), and the port-select, command and data registers read 0.
- R2: Any write to port select (address 0) clears the target selection, data availability, byte pointer, byte count and cycle code, and sets the phase to idle. If the low 3 bits are nonzero, the write also clears active (bit 9) and sets ready (bit 11) and wait-phase (bit 14). A port with a monitor that is not DisplayPort makes data available and clears slave-timeout (bit 10). Any other port sets slave-timeout.
- R3: A command write (address 1) loads the byte count from bits 24:16 and the cycle code from bits 27:25. Bits 7:1 equal to 0x50 select the identification target; any other address leaves the selection unchanged. The command register reads back with bit 30 always 0.
- R4: When command bit 26 (index flag) is set, the byte pointer is loaded from bits 15:8.
- R5: Cycle codes 1, 3, 5 and 7 set the data phase (1) and set active. Code 4 (stop) clears the transfer state, sets idle and clears active, but only when the previously stored code was nonzero. Codes 0, 2 and 6 leave the phase alone.
- R6: A data read (address 3) while command bit 0 (read direction) is set and remaining = count − pointer is positive returns min(4, remaining) fetched bytes, with byte i in bits 8i+7:8i. Higher bytes keep their previous value. The pointer advances once for each byte actually fetched.
- R7: A data read with remaining ≤ 0, or with bit 0 clear, returns the stored data word and changes nothing. Writes to the data register have no effect.
- R8: When a data read sees remaining ≤ 4, the phase becomes idle (0) if cycle-code bit 2 is set and wait (2) otherwise. The transfer state is then cleared.
- R9: A fetched byte is 0, and the pointer does not advance, when no target is selected, when no data is available, or when the pointer is at or above 128.
- R10: A status read returns the current value and then sets in-use (bit 15). A status write with bit 15 set clears in-use. No other status bit is writable.
- R11: A command write with bit 31 (clear-interrupt) set, while the stored bit 31 is 0, clears interrupt (bit 12) and sets ready. While the stored bit 31 is 1, a command write with bit 31 clear resets the controller: only stored bit 31 is cleared, status becomes ready plus slave-timeout when no data is available, and the phase becomes idle. A command write that keeps bit 31 set does nothing.
- R12: When a read and a write fall in the same cycle, the read's effects are applied first and the write's effects override them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | 2 | Register read address |
| rdData | output | 32 | Read data, valid while rdEn is high, else 0 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register write address |
| wrData | input | 32 | Register write data |
| portPresent | input | 8 | Per-port monitor-present flags |
| portIsDp | input | 8 | Per-port DisplayPort flags |
| romWrEn | input | 1 | Identification memory preload strobe |
| romAddr | input | 7 | Preload byte address |
| romData | input | 8 | Preload byte |
| busPhase | output | 2 | Bus phase: 0 idle, 1 data, 2 wait |

## Verification
Two pairs of functions can collide in one cycle. The first pair is a data read that ends a transfer together with a command write that starts a new one. The second is a status read that sets in-use together with a status write that clears it. The bench drives both pairs in the same cycle, then checks through later data reads, status reads and the phase output that the write's effects won. A behavioural model predicts every read word and the phase in every cycle, so any effect applied in the wrong order shows up at once.

// File: rtl/edid_rdr_pkg.sv
package edid_rdr_pkg;
  localparam int DATA_W = 32;

  localparam logic [1:0] REG_PSEL = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int ST_ACTIVE  = 9;
  localparam int ST_TIMEOUT = 10;
  localparam int ST_READY   = 11;
  localparam int ST_INT     = 12;
  localparam int ST_WAIT    = 14;
  localparam int ST_INUSE   = 15;

  localparam int CMD_READ   = 0;
  localparam int CMD_INDEX  = 26;
  localparam int CMD_SWRDY  = 30;
  localparam int CMD_CLRINT = 31;

  localparam logic [6:0] TARGET_ADDR = 7'h50;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_DATA = 2'd1,
    PH_WAIT = 2'd2
  } phase_e;

  typedef struct packed {
    logic       fetch;
    logic [2:0] fetchCount;
    logic       fetchOk;
    logic       rdClear;
    logic       wrLoad;
    logic [7:0] loadVal;
    logic       wrClear;
  } dp_strobe_t;
endpackage

// File: rtl/edid_rdr_datapath.sv
module edid_rdr_datapath
  import edid_rdr_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dp_strobe_t               strobe,
  input  logic                     romWrEn,
  input  logic [$clog2(DEPTH)-1:0] romAddr,
  input  logic [7:0]               romData,
  output logic [7:0]               ptr,
  output logic [LANES*8-1:0]       wordOut
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]         mem [DEPTH];
  logic [LANES*8-1:0] dataReg;
  logic [LANES*8-1:0] mergedWord;
  logic [LANES-1:0]   laneHit;
  logic [7:0]         advance;
  logic [7:0]         ptrNext;

  always_ff @(posedge clk) begin
    if (romWrEn) mem[romAddr] <= romData;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] idx;
    logic       inChunk;
    assign idx        = {1'b0, ptr} + 9'(i);
    assign inChunk    = 3'(i) < strobe.fetchCount;
    assign laneHit[i] = inChunk && strobe.fetchOk && (idx < 9'(DEPTH));
    assign mergedWord[8*i +: 8] = inChunk ? (laneHit[i] ? mem[idx[AW-1:0]] : 8'h00)
                                          : dataReg[8*i +: 8];
  end

  always_comb begin
    advance = '0;
    for (int k = 0; k < LANES; k++) advance = advance + 8'(laneHit[k]);
  end

  always_comb begin
    ptrNext = ptr;
    if (strobe.fetch)   ptrNext = ptr + advance;
    if (strobe.rdClear) ptrNext = '0;
    if (strobe.wrLoad)  ptrNext = strobe.loadVal;
    if (strobe.wrClear) ptrNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      dataReg <= '0;
    end else begin
      ptr <= ptrNext;
      if (strobe.fetch) dataReg <= mergedWord;
    end
  end

  assign wordOut = strobe.fetch ? mergedWord : dataReg;

  // R6: a plain fetch never moves the pointer backwards
  p_ptr_mono_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetch && !strobe.rdClear && !strobe.wrLoad && !strobe.wrClear)
      |=> (ptr >= $past(ptr)));

  // R9: the pointer stops at the end of the record
  p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetch && !strobe.rdClear && !strobe.wrLoad && !strobe.wrClear && ptr >= 8'(DEPTH))
      |=> $stable(ptr));
endmodule

// File: rtl/edid_rdr_ctrl.sv
module edid_rdr_ctrl
  import edid_rdr_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int LANES     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rdEn,
  input  logic [1:0]           rdAddr,
  input  logic                 wrEn,
  input  logic [1:0]           wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [NUM_PORTS-1:0] portPresent,
  input  logic [NUM_PORTS-1:0] portIsDp,
  input  logic [7:0]           ptr,
  input  logic [LANES*8-1:0]   wordOut,
  output dp_strobe_t           strobe,
  output logic [DATA_W-1:0]    rdData,
  output phase_e               phase
);
  localparam int SEL_W = $clog2(NUM_PORTS);

  logic [DATA_W-1:0] portSel, cmdReg, status;
  logic              slaveSel, avail;
  logic [8:0]        total;
  logic [2:0]        cycleType;
  logic signed [9:0] remaining;
  logic              dataRd, lastChunk, statRd;
  logic              pselWr, cmdWr, cmdLive, clrRelease, stopClear;
  logic [2:0]        newCode, oldCode;
  logic [SEL_W-1:0]  newSel;
  logic              availAfterRd;

  assign remaining  = $signed({1'b0, total}) - $signed({2'b0, ptr});
  assign dataRd     = rdEn && rdAddr == REG_DATA && cmdReg[CMD_READ] && remaining > 0;
  assign lastChunk  = dataRd && remaining <= 10'sd4;
  assign statRd     = rdEn && rdAddr == REG_STAT;
  assign pselWr     = wrEn && wrAddr == REG_PSEL;
  assign cmdWr      = wrEn && wrAddr == REG_CMD;
  assign cmdLive    = cmdWr && !cmdReg[CMD_CLRINT];
  assign clrRelease = cmdWr && cmdReg[CMD_CLRINT] && !wrData[CMD_CLRINT];
  assign newCode    = wrData[27:25];
  assign oldCode    = cmdReg[27:25];
  assign stopClear  = cmdLive && newCode == 3'd4 && oldCode != 3'd0;
  assign newSel     = wrData[SEL_W-1:0];
  assign availAfterRd = lastChunk ? 1'b0 : avail;

  always_comb begin
    strobe.fetch      = dataRd;
    strobe.fetchCount = (remaining >= 10'sd4) ? 3'd4 : remaining[2:0];
    strobe.fetchOk    = slaveSel && avail;
    strobe.rdClear    = lastChunk;
    strobe.wrLoad     = cmdLive && wrData[CMD_INDEX];
    strobe.loadVal    = wrData[15:8];
    strobe.wrClear    = pselWr || stopClear;
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (rdAddr)
        REG_PSEL: rdData = portSel;
        REG_CMD:  rdData = cmdReg;
        REG_STAT: rdData = status;
        default:  rdData = wordOut;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portSel   <= '0;
      cmdReg    <= '0;
      status    <= DATA_W'(1) << ST_READY;
      slaveSel  <= 1'b0;
      avail     <= 1'b0;
      total     <= '0;
      cycleType <= '0;
      phase     <= PH_IDLE;
    end else begin
      // read side effects first
      if (statRd) status[ST_INUSE] <= 1'b1;
      if (lastChunk) begin
        phase     <= cycleType[2] ? PH_IDLE : PH_WAIT;
        slaveSel  <= 1'b0;
        avail     <= 1'b0;
        total     <= '0;
        cycleType <= '0;
      end
      // write side effects override
      if (pselWr) begin
        portSel   <= wrData;
        slaveSel  <= 1'b0;
        avail     <= 1'b0;
        total     <= '0;
        cycleType <= '0;
        phase     <= PH_IDLE;
        if (newSel != '0) begin
          status[ST_ACTIVE] <= 1'b0;
          status[ST_READY]  <= 1'b1;
          status[ST_WAIT]   <= 1'b1;
          if (portPresent[newSel] && !portIsDp[newSel]) begin
            avail               <= 1'b1;
            status[ST_TIMEOUT]  <= 1'b0;
          end else begin
            status[ST_TIMEOUT]  <= 1'b1;
          end
        end
      end
      if (clrRelease) begin
        cmdReg[CMD_CLRINT] <= 1'b0;
        status <= (DATA_W'(1) << ST_READY) | (availAfterRd ? '0 : (DATA_W'(1) << ST_TIMEOUT));
        phase  <= PH_IDLE;
      end
      if (cmdLive) begin
        if (wrData[CMD_CLRINT]) begin
          status[ST_INT]   <= 1'b0;
          status[ST_READY] <= 1'b1;
        end
        total     <= wrData[24:16];
        cycleType <= newCode;
        if (wrData[7:1] == TARGET_ADDR) slaveSel <= 1'b1;
        if (newCode[0]) begin
          phase             <= PH_DATA;
          status[ST_ACTIVE] <= 1'b1;
        end else if (stopClear) begin
          slaveSel          <= 1'b0;
          avail             <= 1'b0;
          total             <= '0;
          cycleType         <= '0;
          phase             <= PH_IDLE;
          status[ST_ACTIVE] <= 1'b0;
        end
        cmdReg <= wrData & ~(DATA_W'(1) << CMD_SWRDY);
      end
      if (wrEn && wrAddr == REG_STAT && wrData[ST_INUSE]) status[ST_INUSE] <= 1'b0;
    end
  end

  // R10: a status read leaves in-use set unless a same-cycle write removes it
  p_inuse_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && !(wrEn && wrAddr == REG_STAT) && !clrRelease) |=> status[ST_INUSE]);

  // R5: data cycle codes open the data phase
  p_data_active_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdLive && wrData[25]) |=> (status[ST_ACTIVE] && phase == PH_DATA));

  // R5: stop after a real cycle returns to idle
  p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    stopClear |=> (phase == PH_IDLE && !status[ST_ACTIVE] && !slaveSel && total == 9'd0));

  // R2: a port-select write drops the transfer state
  p_psel_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    pselWr |=> (!slaveSel && total == 9'd0 && cycleType == 3'd0));

  // R8: the final chunk leaves the data phase when no write interferes
  p_final_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lastChunk && !wrEn) |=> (phase != PH_DATA && total == 9'd0));

  // R3: the software-ready bit never sticks in the command register
  p_swrdy_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdLive |=> !cmdReg[CMD_SWRDY]);
endmodule

// File: rtl/edid_bus_reader.sv
module edid_bus_reader
  import edid_rdr_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int DEPTH     = 128,
  parameter int LANES     = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rdEn,
  input  logic [1:0]               rdAddr,
  output logic [31:0]              rdData,
  input  logic                     wrEn,
  input  logic [1:0]               wrAddr,
  input  logic [31:0]              wrData,
  input  logic [NUM_PORTS-1:0]     portPresent,
  input  logic [NUM_PORTS-1:0]     portIsDp,
  input  logic                     romWrEn,
  input  logic [$clog2(DEPTH)-1:0] romAddr,
  input  logic [7:0]               romData,
  output logic [1:0]               busPhase
);
  dp_strobe_t         strobe;
  logic [7:0]         ptr;
  logic [LANES*8-1:0] wordOut;
  phase_e             phase;

  edid_rdr_ctrl #(.NUM_PORTS(NUM_PORTS), .LANES(LANES)) i_ctrl (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .portPresent(portPresent),
    .portIsDp(portIsDp), .ptr(ptr), .wordOut(wordOut), .strobe(strobe),
    .rdData(rdData), .phase(phase)
  );

  edid_rdr_datapath #(.DEPTH(DEPTH), .LANES(LANES)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .romWrEn(romWrEn),
    .romAddr(romAddr), .romData(romData), .ptr(ptr), .wordOut(wordOut)
  );

  assign busPhase = phase;
endmodule

// File: tb/test_edid_bus_reader.sv
module test_edid_bus_reader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0, wrEn = 1'b0, romWrEn = 1'b0;
  logic [1:0]  rdAddr = '0, wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [6:0]  romAddr = '0;
  logic [7:0]  romData = '0;
  logic [7:0]  portPresent = 8'b0010_0110;
  logic [7:0]  portIsDp    = 8'b0000_0100;
  logic [31:0] rdData;
  logic [1:0]  busPhase;

  int checks = 0, fails = 0;
  bit finished = 0;

  edid_bus_reader i_edid_bus_reader (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .portPresent(portPresent),
    .portIsDp(portIsDp), .romWrEn(romWrEn), .romAddr(romAddr), .romData(romData),
    .busPhase(busPhase)
  );

  always #10 clk = ~clk;

  // reference model state
  bit [7:0]  mem [128];
  bit [31:0] mPsel, mCmd, mStat, mData;
  int        mPhase, mPtr, mTotal, mCycle;
  bit        mSel, mAvail;

  task automatic modelInit();
    mPtr = 0; mTotal = 0; mCycle = 0; mSel = 0; mAvail = 0; mPhase = 0;
  endtask

  task automatic modelStep(input bit re, input int ra, input bit we, input int wa,
                           input bit [31:0] wd, output bit [31:0] exp);
    int rem, n, sel;
    exp = 0;
    if (re) begin
      if (ra == 0) exp = mPsel;
      else if (ra == 1) exp = mCmd;
      else if (ra == 2) begin exp = mStat; mStat[15] = 1; end
      else begin
        rem = mTotal - mPtr;
        if (mCmd[0] && rem > 0) begin
          n = (rem > 4) ? 4 : rem;
          for (int i = 0; i < n; i++) begin
            if (mSel && mAvail && mPtr < 128) begin
              mData[8*i +: 8] = mem[mPtr]; mPtr++;
            end else mData[8*i +: 8] = 8'h00;
          end
          exp = mData;
          if (rem <= 4) begin
            mPhase = (mCycle >= 4) ? 0 : 2;
            modelInit_keepPhase();
          end
        end else exp = mData;
      end
    end
    if (we) begin
      if (wa == 0) begin
        mPsel = wd; modelInit();
        sel = wd[2:0];
        if (sel != 0) begin
          mStat[9] = 0; mStat[11] = 1; mStat[14] = 1;
          if (portPresent[sel] && !portIsDp[sel]) begin mAvail = 1; mStat[10] = 0; end
          else mStat[10] = 1;
        end
      end else if (wa == 1) begin
        if (mCmd[31]) begin
          if (!wd[31]) begin
            mCmd[31] = 0;
            mStat = 32'h800 | (mAvail ? 32'h0 : 32'h400);
            mPhase = 0;
          end
        end else begin
          if (wd[31]) begin mStat[12] = 0; mStat[11] = 1; end
          mTotal = wd[24:16];
          if (wd[7:1] == 7'h50) mSel = 1;
          if (wd[26]) mPtr = wd[15:8];
          mCycle = wd[27:25];
          if (mCycle % 2 == 1) begin mPhase = 1; mStat[9] = 1; end
          else if (mCycle == 4 && mCmd[27:25] != 0) begin modelInit(); mStat[9] = 0; end
          mCmd = wd; mCmd[30] = 0;
        end
      end else if (wa == 2) begin
        if (wd[15]) mStat[15] = 0;
      end
    end
  endtask

  task automatic modelInit_keepPhase();
    mPtr = 0; mTotal = 0; mCycle = 0; mSel = 0; mAvail = 0;
  endtask

  task automatic check(input string tag, input string what, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  // one bus cycle; compared against the model every clock
  task automatic cyc(input string tag, input bit re, input int ra, input bit we,
                     input int wa, input bit [31:0] wd);
    bit [31:0] exp;
    int        expPhase;
    @(negedge clk);
    rdEn = re; rdAddr = 2'(ra); wrEn = we; wrAddr = 2'(wa); wrData = wd;
    expPhase = mPhase;
    modelStep(re, ra, we, wa, wd, exp);
    #5;
    check(tag, "phase", 32'(busPhase), 32'(expPhase));
    if (re) check(tag, "rdData", rdData, exp);
    @(posedge clk);
    #1; rdEn = 0; wrEn = 0;
  endtask

  task automatic rd(input string tag, input int ra);  cyc(tag, 1, ra, 0, 0, 0); endtask
  task automatic wr(input string tag, input int wa, input bit [31:0] wd); cyc(tag, 0, 0, 1, wa, wd); endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    mPsel = 0; mCmd = 0; mStat = 32'h800; mData = 0; modelInit();
    for (int k = 0; k < 128; k++) mem[k] = 8'((k * 37 + 11) & 255);
    for (int k = 0; k < 128; k++) begin
      @(negedge clk); romWrEn = 1; romAddr = 7'(k); romData = mem[k];
    end
    @(negedge clk); romWrEn = 0;
    repeat (2) @(negedge clk);
    rstN = 1;

    // R1 reset state
    rd("R1", 2); rd("R1", 1); rd("R1", 0); rd("R1", 3);
    // R10 in-use handling
    rd("R10", 2); wr("R10", 2, 32'h0000_7FFF); rd("R10", 2);
    wr("R10", 2, 32'h0000_8000); cyc("R10", 1, 1, 0, 0, 0); rd("R10", 2);
    // R2 port selection
    wr("R2", 0, 1); rd("R2", 2);
    wr("R2", 0, 3); rd("R2", 2);
    wr("R2", 0, 2); rd("R2", 2);
    wr("R2", 0, 0); rd("R2", 2); rd("R2", 0);
    // R3 R6 R7 R8 plain read with stop
    wr("R3", 0, 1); wr("R3", 1, 32'h4A0A_00A1); rd("R3", 1);
    rd("R6", 3); rd("R6", 3); rd("R8", 3); rd("R7", 3);
    wr("R7", 3, 32'hFFFF_FFFF); rd("R7", 3);
    // R4 R9 indexed read past the record end
    wr("R4", 0, 1); wr("R4", 1, 32'h0E82_7CA1); rd("R4", 3); rd("R9", 3); rd("R9", 3);
    // R8 wait phase after a non-stop cycle
    wr("R8", 0, 1); wr("R8", 1, 32'h0203_00A1); rd("R8", 3); rd("R8", 2);
    // R9 wrong target and absent monitor
    wr("R9", 0, 1); wr("R9", 1, 32'h0204_00A3); rd("R9", 3);
    wr("R9", 0, 3); wr("R9", 1, 32'h0204_00A1); rd("R9", 3);
    // R5 stop handling
    wr("R5", 0, 1); wr("R5", 1, 32'h0208_00A1); wr("R5", 1, 32'h0000_00A1);
    wr("R5", 1, 32'h0800_00A1); rd("R5", 2);
    wr("R5", 1, 32'h0208_00A1); wr("R5", 1, 32'h0800_00A1); rd("R5", 2); rd("R5", 3);
    // R11 clear-interrupt handshake
    wr("R11", 0, 1); wr("R11", 1, 32'h8000_0000); rd("R11", 2); rd("R11", 1);
    wr("R11", 1, 32'h8000_0000); wr("R11", 1, 32'h0000_0000); rd("R11", 2); rd("R11", 1);
    wr("R11", 0, 3); wr("R11", 1, 32'h8000_0000); wr("R11", 1, 32'h0); rd("R11", 2);
    // R12 same-cycle read and write
    wr("R12", 0, 1); wr("R12", 1, 32'h0A04_00A1);
    cyc("R12", 1, 3, 1, 1, 32'h0A08_00A1);
    rd("R12", 3); rd("R12", 3); rd("R12", 2);
    cyc("R12", 1, 2, 1, 2, 32'h0000_8000); rd("R12", 2);
    rd("R12", 2);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule